// File: doc/BRIEF.md
# Configurable Host Bus Interface Decoder

This block sits between an 8-bit host processor bus and the internal memory and I/O resources of a device. It turns the host's control pins into clean internal read, write and program-fetch enables. One pair of pins serves two kinds of host, chosen by a static configuration input. The first kind drives separate active-low read and write strobes. The second drives a direction line together with an active-high enable. A separate active-low fetch strobe reads the program store. A host that has no such strobe ties it high and reads through the normal read path.

The low multiplexed address lines and the upper address lines are captured on the trailing edge of an address strobe whose polarity is configurable. The middle address lines pass straight through. A dual-role pin acts either as a chip select or as address bit 19. As a chip select, driving it high powers the device down. As address bit 19, it is either an address bit (latched or transparent) or a plain logic input. The reset input has a configurable polarity. It passes a digital width filter, so pulses shorter than the minimum width are ignored.

All pins are brought into the clock domain through a synchronizer of `SYNC_STAGES` flops. Polarity normalization happens ahead of the synchronizer, so changing a polarity bit together with its pin causes no spurious edge.

Top module: `host_bus_decoder`

## Requirements
- R1: With `cfg_rw_mode`=0, `pin_rd` low alone gives `rd_en`=1 and `pin_wr` low alone gives `wr_en`=1. With both high, or both low, neither enable is asserted.
- R2: With `cfg_rw_mode`=1, `pin_rd` is an active-high enable and `pin_wr` is the direction line. Enable 0 does nothing. Enable 1 with direction 1 gives `rd_en`. Enable 1 with direction 0 gives `wr_en`.
- R3: `fetch_en` is 1 while `pin_fetch_n` is low, and 0 while it is high.
- R4: `pin_as` is active high when `cfg_as_high`=1 and active low otherwise. On its trailing edge, `pin_ad` is captured into `addr_out[7:0]` and `pin_ahi` into `addr_out[18:16]`. These bits then hold while the strobe stays inactive, whatever the pins do.
- R5: `addr_out[15:8]` follows `pin_amid` without latching.
- R6: With `cfg_sel_is_addr`=0, `pin_sel` high sets `pdown`=1, forces `rd_en`, `wr_en` and `fetch_en` to 0, and `addr_out[19]` reads 0. `pin_sel` low clears `pdown`.
- R7: With `cfg_sel_is_addr`=1, `pdown` is always 0. If `cfg_a19_addr`=1, `addr_out[19]` is the pin level captured at the strobe's trailing edge when `cfg_a19_latch`=1, and the live pin level when it is 0. If `cfg_a19_addr`=0, `sel_logic` follows the pin and `addr_out[19]` is 0. `sel_logic` is 0 whenever the pin is not a logic input.
- R8: `pin_rst` is active high when `cfg_rst_high`=1 and active low otherwise. An active pulse of at least ceil(RST_MIN_NS/CLK_PERIOD_NS) clock cycles asserts `rst_out`, and a shorter pulse leaves it low. While `rst_out` is 1, all enables are 0 and the latched address bits clear to 0.
- R9: `rd_en` and `wr_en` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| cfg_rw_mode | input | 1 | 0: separate strobes, 1: direction plus enable |
| cfg_as_high | input | 1 | Address strobe polarity, 1 = active high |
| cfg_sel_is_addr | input | 1 | 0: dual pin is chip select, 1: address bit 19 |
| cfg_a19_addr | input | 1 | 1: bit 19 is an address, 0: logic input |
| cfg_a19_latch | input | 1 | 1: bit 19 latched on strobe, 0: transparent |
| cfg_rst_high | input | 1 | Reset polarity, 1 = active high |
| pin_rst | input | 1 | Host reset pin |
| pin_fetch_n | input | 1 | Active-low program fetch strobe |
| pin_wr | input | 1 | Write strobe (low) or direction line |
| pin_rd | input | 1 | Read strobe (low) or enable (high) |
| pin_as | input | 1 | Address strobe |
| pin_ad | input | LO_W | Multiplexed low address lines |
| pin_amid | input | MID_W | Middle address lines |
| pin_ahi | input | HI_W | Upper address lines |
| pin_sel | input | 1 | Dual-role select / address pin |
| rst_out | output | 1 | Filtered internal reset, active high |
| pdown | output | 1 | Power-down indication |
| rd_en | output | 1 | Internal read enable |
| wr_en | output | 1 | Internal write enable |
| fetch_en | output | 1 | Internal program fetch enable |
| addr_out | output | LO_W+MID_W+HI_W+1 | Full address to downstream decode |
| sel_logic | output | 1 | Dual pin as a logic input |

## Verification
The bench drives reset pulses of exactly the minimum width and of one cycle less. A filter that is off by one would assert reset on the short pulse or miss the exact one. It also drives both separate strobes low together; a decoder without mutual exclusion would raise read and write at once. The bench changes the address lines while the strobe is idle and flips the strobe polarity along with its pin. A level latch, or normalization done after synchronization, would then corrupt the held address. Chip select high with a read pending checks power-down gating. Bit 19 is toggled between strobes in latched and transparent modes to separate the two paths.

// File: rtl/hbd_pkg.sv
`timescale 1ns/1ps
package hbd_pkg;
   function automatic int min_rst_cycles(input int min_ns, input int clk_ns);
      int c;
      c = (min_ns + clk_ns - 1) / clk_ns;
      return (c < 1) ? 1 : c;
   endfunction
endpackage

// File: rtl/hbd_sync.sv
`timescale 1ns/1ps
module hbd_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain = '0;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) chain[0] <= d;
      end else begin : g_multi
         always_ff @(posedge clk) chain <= {chain[STAGES-2:0], d};
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hbd_rst_filter.sv
`timescale 1ns/1ps
module hbd_rst_filter #(
   parameter int MIN_CYC = 10
) (
   input  logic clk,
   input  logic act_s,
   output logic rst_o
);
   localparam int CW = $clog2(MIN_CYC + 1);
   localparam logic [CW-1:0] TOP = CW'(MIN_CYC);

   logic [CW-1:0] cnt = '0;

   always_ff @(posedge clk) begin
      if (!act_s)          cnt <= '0;
      else if (cnt != TOP) cnt <= cnt + 1'b1;
   end

   assign rst_o = (cnt == TOP);

   // R8: an inactive input always drops the filtered reset
   a_r8_release: assert property (@(posedge clk) !act_s |=> !rst_o);
   // R8: a held pulse reaching the width threshold raises reset
   a_r8_reach: assert property (@(posedge clk) (cnt == TOP - 1'b1) && act_s |=> rst_o);
endmodule

// File: rtl/hbd_strobe_dec.sv
`timescale 1ns/1ps
module hbd_strobe_dec (
   input  logic rw_mode,
   input  logic wr_pin,
   input  logic rd_pin,
   input  logic fetch_act,
   input  logic block,
   output logic rd_en,
   output logic wr_en,
   output logic fetch_en
);
   logic rd_raw, wr_raw;

   always_comb begin
      if (rw_mode) begin
         rd_raw = rd_pin & wr_pin;
         wr_raw = rd_pin & ~wr_pin;
      end else begin
         rd_raw = ~rd_pin & wr_pin;
         wr_raw = ~wr_pin & rd_pin;
      end
      rd_en    = rd_raw & ~block;
      wr_en    = wr_raw & ~block;
      fetch_en = fetch_act & ~block;
   end
endmodule

// File: rtl/hbd_addr_latch.sv
`timescale 1ns/1ps
module hbd_addr_latch #(
   parameter int LO_W       = 8,
   parameter int HI_W       = 3,
   parameter bit HI_LATCHED = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            as_act,
   input  logic [LO_W-1:0] lo_d,
   input  logic [HI_W-1:0] hi_d,
   input  logic            x_d,
   output logic [LO_W-1:0] lo_q,
   output logic [HI_W-1:0] hi_q,
   output logic            x_q
);
   logic as_d = 1'b0;
   logic trail;
   logic [LO_W-1:0] lo_r = '0;
   logic            x_r  = 1'b0;

   always_ff @(posedge clk) as_d <= as_act;
   assign trail = as_d & ~as_act;

   always_ff @(posedge clk) begin
      if (rst) begin
         lo_r <= '0;
         x_r  <= 1'b0;
      end else if (trail) begin
         lo_r <= lo_d;
         x_r  <= x_d;
      end
   end
   assign lo_q = lo_r;
   assign x_q  = x_r;

   generate
      if (HI_LATCHED) begin : g_hi_latched
         logic [HI_W-1:0] hi_r = '0;
         always_ff @(posedge clk) begin
            if (rst)        hi_r <= '0;
            else if (trail) hi_r <= hi_d;
         end
         assign hi_q = hi_r;
      end else begin : g_hi_through
         assign hi_q = hi_d;
      end
   endgenerate

   // R4: with the strobe idle for two samples the captured low bits hold
   a_r4_hold: assert property (@(posedge clk) disable iff (rst)
      (!as_act && !as_d) |=> $stable(lo_q));
endmodule

// File: rtl/host_bus_decoder.sv
`timescale 1ns/1ps
module host_bus_decoder #(
   parameter int LO_W          = 8,
   parameter int MID_W         = 8,
   parameter int HI_W          = 3,
   parameter int SYNC_STAGES   = 2,
   parameter int CLK_PERIOD_NS = 10,
   parameter int RST_MIN_NS    = 100,
   parameter bit HI_LATCHED    = 1'b1
) (
   input  logic                        clk,
   input  logic                        cfg_rw_mode,
   input  logic                        cfg_as_high,
   input  logic                        cfg_sel_is_addr,
   input  logic                        cfg_a19_addr,
   input  logic                        cfg_a19_latch,
   input  logic                        cfg_rst_high,
   input  logic                        pin_rst,
   input  logic                        pin_fetch_n,
   input  logic                        pin_wr,
   input  logic                        pin_rd,
   input  logic                        pin_as,
   input  logic [LO_W-1:0]             pin_ad,
   input  logic [MID_W-1:0]            pin_amid,
   input  logic [HI_W-1:0]             pin_ahi,
   input  logic                        pin_sel,
   output logic                        rst_out,
   output logic                        pdown,
   output logic                        rd_en,
   output logic                        wr_en,
   output logic                        fetch_en,
   output logic [LO_W+MID_W+HI_W:0]    addr_out,
   output logic                        sel_logic
);
   import hbd_pkg::*;

   localparam int MIN_CYC = min_rst_cycles(RST_MIN_NS, CLK_PERIOD_NS);
   localparam int SW      = 6 + LO_W + MID_W + HI_W;

   generate
      if (LO_W < 1 || MID_W < 0 || HI_W < 1) begin : g_bad_width
         $error("address field widths out of range");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (CLK_PERIOD_NS < 1 || RST_MIN_NS < 1) begin : g_bad_time
         $error("timing parameters must be positive");
      end
   endgenerate

   // polarity normalization ahead of the synchronizer
   logic rst_act_raw, as_act_raw, fetch_act_raw;
   assign rst_act_raw   = ~(pin_rst ^ cfg_rst_high);
   assign as_act_raw    = ~(pin_as ^ cfg_as_high);
   assign fetch_act_raw = ~pin_fetch_n;

   logic [SW-1:0] raw_bus, syn_bus;
   assign raw_bus = {rst_act_raw, fetch_act_raw, pin_wr, pin_rd, as_act_raw,
                     pin_sel, pin_ahi, pin_amid, pin_ad};

   hbd_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .d   (raw_bus),
      .q   (syn_bus)
   );

   logic              rst_act_s, fetch_act_s, wr_s, rd_s, as_act_s, sel_s;
   logic [HI_W-1:0]   ahi_s;
   logic [MID_W-1:0]  amid_s;
   logic [LO_W-1:0]   ad_s;
   assign {rst_act_s, fetch_act_s, wr_s, rd_s, as_act_s,
           sel_s, ahi_s, amid_s, ad_s} = syn_bus;

   logic rst_int;
   hbd_rst_filter #(.MIN_CYC(MIN_CYC)) u_rst (
      .clk   (clk),
      .act_s (rst_act_s),
      .rst_o (rst_int)
   );

   logic pd_int;
   assign pd_int = ~cfg_sel_is_addr & sel_s;

   hbd_strobe_dec u_dec (
      .rw_mode   (cfg_rw_mode),
      .wr_pin    (wr_s),
      .rd_pin    (rd_s),
      .fetch_act (fetch_act_s),
      .block     (pd_int | rst_int),
      .rd_en     (rd_en),
      .wr_en     (wr_en),
      .fetch_en  (fetch_en)
   );

   logic [LO_W-1:0] lo_q;
   logic [HI_W-1:0] hi_q;
   logic            a19_q;
   hbd_addr_latch #(.LO_W(LO_W), .HI_W(HI_W), .HI_LATCHED(HI_LATCHED)) u_lat (
      .clk    (clk),
      .rst    (rst_int),
      .as_act (as_act_s),
      .lo_d   (ad_s),
      .hi_d   (ahi_s),
      .x_d    (sel_s),
      .lo_q   (lo_q),
      .hi_q   (hi_q),
      .x_q    (a19_q)
   );

   logic a19_bit;
   always_comb begin
      if (cfg_sel_is_addr && cfg_a19_addr) a19_bit = cfg_a19_latch ? a19_q : sel_s;
      else                                 a19_bit = 1'b0;
   end

   assign sel_logic = cfg_sel_is_addr & ~cfg_a19_addr & sel_s;
   assign addr_out  = {a19_bit, hi_q, amid_s, lo_q};
   assign pdown     = pd_int;
   assign rst_out   = rst_int;

   // R9: read and write never coincide
   a_r9_exclusive: assert property (@(posedge clk) !(rd_en && wr_en));
   // R6: power-down silences every enable
   a_r6_pdown_quiet: assert property (@(posedge clk)
      pdown |-> (!rd_en && !wr_en && !fetch_en));
   // R8: filtered reset silences every enable
   a_r8_rst_quiet: assert property (@(posedge clk)
      rst_out |-> (!rd_en && !wr_en && !fetch_en));
   // R7: address role of the dual pin never powers down
   a_r7_no_pdown: assert property (@(posedge clk) cfg_sel_is_addr |-> !pdown);
   // R2: enable-plus-direction host reads when both synchronized lines are high
   a_r2_rw_read: assert property (@(posedge clk)
      (cfg_rw_mode && rd_s && wr_s && !pdown && !rst_out) |-> rd_en);
endmodule

// File: tb/host_bus_decoder_bench.sv
`timescale 1ns/1ps
module host_bus_decoder_bench;
   localparam int CLK_PERIOD = 10;
   localparam int LO_W = 8, MID_W = 8, HI_W = 3, SYNC = 2;
   localparam int MIN_CYC = 10;
   localparam int SETTLE = SYNC + 3;
   localparam int AW = LO_W + MID_W + HI_W + 1;

   logic clk = 1'b0;
   logic cfg_rw_mode = 0, cfg_as_high = 1, cfg_sel_is_addr = 0;
   logic cfg_a19_addr = 0, cfg_a19_latch = 0, cfg_rst_high = 1;
   logic pin_rst = 0, pin_fetch_n = 1, pin_wr = 1, pin_rd = 1, pin_as = 0, pin_sel = 0;
   logic [LO_W-1:0] pin_ad = '0;
   logic [MID_W-1:0] pin_amid = '0;
   logic [HI_W-1:0] pin_ahi = '0;
   logic rst_out, pdown, rd_en, wr_en, fetch_en, sel_logic;
   logic [AW-1:0] addr_out;

   int n_chk = 0, n_fail = 0;
   logic [LO_W-1:0] m_lo = '0;
   logic [HI_W-1:0] m_hi = '0;
   logic m_a19 = 0, m_rst = 0, rst_seen = 0;

   host_bus_decoder #(.LO_W(LO_W), .MID_W(MID_W), .HI_W(HI_W), .SYNC_STAGES(SYNC),
      .CLK_PERIOD_NS(CLK_PERIOD), .RST_MIN_NS(100)) u_host_bus_decoder (
      .clk(clk), .cfg_rw_mode(cfg_rw_mode), .cfg_as_high(cfg_as_high),
      .cfg_sel_is_addr(cfg_sel_is_addr), .cfg_a19_addr(cfg_a19_addr),
      .cfg_a19_latch(cfg_a19_latch), .cfg_rst_high(cfg_rst_high), .pin_rst(pin_rst),
      .pin_fetch_n(pin_fetch_n), .pin_wr(pin_wr), .pin_rd(pin_rd), .pin_as(pin_as),
      .pin_ad(pin_ad), .pin_amid(pin_amid), .pin_ahi(pin_ahi), .pin_sel(pin_sel),
      .rst_out(rst_out), .pdown(pdown), .rd_en(rd_en), .wr_en(wr_en),
      .fetch_en(fetch_en), .addr_out(addr_out), .sel_logic(sel_logic));

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(negedge clk) if (rst_out) rst_seen = 1'b1;

   function automatic logic f_pd();
      return !cfg_sel_is_addr && pin_sel;
   endfunction
   function automatic logic f_rd();
      if (f_pd() || m_rst) return 0;
      return cfg_rw_mode ? (pin_rd && pin_wr) : (!pin_rd && pin_wr);
   endfunction
   function automatic logic f_wr();
      if (f_pd() || m_rst) return 0;
      return cfg_rw_mode ? (pin_rd && !pin_wr) : (!pin_wr && pin_rd);
   endfunction
   function automatic logic f_a19();
      if (!(cfg_sel_is_addr && cfg_a19_addr)) return 0;
      return cfg_a19_latch ? m_a19 : pin_sel;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic settle();
      repeat (SETTLE) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check_all();
      string rq;
      rq = cfg_rw_mode ? "R2" : "R1";
      chk(rq, "rd_en", 32'(rd_en), 32'(f_rd()));
      chk(rq, "wr_en", 32'(wr_en), 32'(f_wr()));
      chk("R9", "exclusive", 32'(rd_en && wr_en), 32'd0);
      chk("R3", "fetch_en", 32'(fetch_en), 32'(!pin_fetch_n && !f_pd() && !m_rst));
      chk("R6", "pdown", 32'(pdown), 32'(f_pd()));
      chk("R4", "addr_lo", 32'(addr_out[LO_W-1:0]), 32'(m_lo));
      chk("R4", "addr_hi", 32'(addr_out[AW-2 -: HI_W]), 32'(m_hi));
      chk("R5", "addr_mid", 32'(addr_out[LO_W +: MID_W]), 32'(pin_amid));
      chk("R7", "addr_19", 32'(addr_out[AW-1]), 32'(f_a19()));
      chk("R7", "sel_logic", 32'(sel_logic),
          32'(cfg_sel_is_addr && !cfg_a19_addr && pin_sel));
      chk("R8", "rst_out", 32'(rst_out), 32'(m_rst));
   endtask

   task automatic set_cfg(input logic [5:0] c);
      @(negedge clk);
      {cfg_rw_mode, cfg_as_high, cfg_sel_is_addr, cfg_a19_addr, cfg_a19_latch, cfg_rst_high} = c;
      pin_wr = !cfg_rw_mode; pin_rd = !cfg_rw_mode; pin_fetch_n = 1;
      pin_as = !cfg_as_high; pin_rst = !cfg_rst_high;
      settle();
   endtask

   task automatic addr_cycle(input logic [LO_W-1:0] lo, input logic [MID_W-1:0] mid,
                             input logic [HI_W-1:0] hi, input logic sel);
      @(negedge clk);
      pin_ad = lo; pin_amid = mid; pin_ahi = hi; pin_sel = sel;
      pin_as = cfg_as_high;
      settle();
      pin_as = !cfg_as_high;
      settle();
      m_lo = lo; m_hi = hi; m_a19 = sel;
      check_all();
      // R4 hold: change lines with the strobe idle
      pin_ad = ~lo; pin_ahi = ~hi; pin_amid = ~mid; pin_sel = !sel;
      settle();
      check_all();
   endtask

   task automatic bus_op(input logic wr, input logic rd, input logic fn, input logic sel);
      @(negedge clk);
      pin_wr = wr; pin_rd = rd; pin_fetch_n = fn; pin_sel = sel;
      settle();
      check_all();
   endtask

   task automatic rst_pulse(input int n);
      @(negedge clk);
      rst_seen = 0;
      pin_rst = cfg_rst_high;
      repeat (n) @(negedge clk);
      pin_rst = !cfg_rst_high;
      settle();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'h1A2B3C));
      // power-up reset, active high
      @(negedge clk);
      pin_rst = 1;
      repeat (MIN_CYC + 4) @(negedge clk);
      pin_rst = 0;
      settle();
      check_all();  // reset state: R8 released, address cleared

      // R1 directed
      set_cfg(6'b010001);
      bus_op(1, 0, 1, 0);
      bus_op(0, 1, 1, 0);
      bus_op(0, 0, 1, 0);   // R9: both strobes low gives nothing
      bus_op(1, 1, 0, 0);   // R3 fetch
      // R2 directed
      set_cfg(6'b110001);
      bus_op(0, 0, 1, 0);
      bus_op(1, 1, 1, 0);
      bus_op(0, 1, 1, 0);
      // R6 chip select high with a read pending
      bus_op(1, 1, 0, 1);
      // R4 active-low strobe, R5 pass-through
      set_cfg(6'b000001);
      addr_cycle(8'hA5, 8'h3C, 3'b101, 0);
      // R7 latched then transparent bit 19
      set_cfg(6'b011111);
      addr_cycle(8'h5A, 8'hC3, 3'b010, 1);
      set_cfg(6'b011101);
      addr_cycle(8'h11, 8'h22, 3'b011, 1);
      set_cfg(6'b011001);
      bus_op(1, 1, 1, 1);   // R7 logic input
      bus_op(1, 1, 1, 0);

      // R8 width boundary, active low polarity
      set_cfg(6'b010000);
      addr_cycle(8'h77, 8'h01, 3'b110, 0);
      rst_pulse(MIN_CYC - 1);
      chk("R8", "short pulse ignored", 32'(rst_seen), 32'd0);
      check_all();
      rst_pulse(MIN_CYC);
      chk("R8", "min pulse accepted", 32'(rst_seen), 32'd1);
      m_lo = '0; m_hi = '0; m_a19 = 0;
      check_all();
      // R8 long reset blocks a pending read
      @(negedge clk);
      pin_rd = 0; pin_rst = cfg_rst_high;
      repeat (MIN_CYC + SETTLE) @(negedge clk);
      m_rst = 1;
      check_all();
      pin_rst = !cfg_rst_high;
      settle();
      m_rst = 0;
      check_all();

      // constrained random mix
      for (int it = 0; it < 150; it++) begin
         if (it % 12 == 0) begin
            logic [5:0] c;
            c = 6'($urandom());
            set_cfg(c);
         end
         if ($urandom_range(0, 3) == 0)
            addr_cycle(LO_W'($urandom()), MID_W'($urandom()), HI_W'($urandom()),
                       1'($urandom()));
         else
            bus_op(1'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()));
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule